// File: doc/BRIEF.md
# Table-Driven Arbitrary Waveform Generator

This block plays back a programmable sample table through a phase accumulator and delivers one clipped, signed sample per clock. A host loads the table through a dedicated write port and configures playback through a small register write port. Configurable values are the per-clock phase increment, the phase value at which the accumulator folds back, the phase loaded when playback starts, a gain and a signed offset. Single-bit controls select the trigger source, single-pass or repeating playback, the fold-back rule, a forced-zero output and a hold that parks the sequencer.

The table holds `2**ADDR_W` entries of `DATA_W`-bit two's-complement samples, where `2**(DATA_W-1)` stands for 1.0. The full-size arrangement is `ADDR_W = 14` (16384 entries) with a fold value of `0x3FFFFFFF`. The default parameters use a smaller table with the same 16 fractional phase bits. The trigger input is taken as already synchronous to `clk`.

Register map on `cfg_addr`: 0 = control (bits [2:0] trigger source, [3] single-pass, [4] carry-over fold, [5] force zero, [6] hold); 1 = scaling (bits [DATA_W-1:0] unsigned gain, bits [15+DATA_W:16] signed offset); 2 = fold value; 3 = start phase; 4 = phase increment. Addresses 5 to 7 are ignored.

Top module: `tbl_wavegen`

## Requirements
- R1: Synchronous active-high reset clears the output register to 0, the gain, offset, control word, start phase and increment to 0, and sets the fold value to `2**(FRAC_W+ADDR_W)-1`.
- R2: The output equals floor(sample × gain / 2**(DATA_W-1)) + offset, where the sample is the table entry at index = phase bits [FRAC_W+ADDR_W-1:FRAC_W].
- R3: When that sum lies outside the signed DATA_W-bit range, the output saturates to the nearest end (8191 or -8192 by default) and does not wrap.
- R4: The phase held after a clock edge shows at the output two edges later. A write to the scaling or control register shows at the output one edge after the write.
- R5: While running, each clock the phase grows by the increment as long as the sum does not exceed the fold value.
- R6: In repeating playback with carry-over fold (control bit 4 = 1), a sum above the fold value becomes sum − (fold value + 1).
- R7: In repeating playback with carry-over fold off, a sum above the fold value restarts the phase at 0 (table index 0).
- R8: In single-pass playback (control bit 3 = 1), a sum above the fold value stops the sequencer, the phase freezes, and the last sample is held until hold is asserted.
- R9: Trigger source codes are 0 never, 1 at once, 2 rising edge of `trig_in`, 3 falling edge, 4 `trig_in` high, 5 always. A trigger acts only while idle and loads the start phase into the accumulator.
- R10: Edge sources compare `trig_in` with its value one clock earlier. A level that stays unchanged starts nothing under codes 2 and 3.
- R11: Control bit 5 forces the output to 0 while set.
- R12: Control bit 6 holds the phase at 0 in the idle state, so the output shows table entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | PHASE_W | Register write data |
| tbl_we | input | 1 | Sample table write strobe |
| tbl_addr | input | ADDR_W | Sample table write index |
| tbl_wdata | input | DATA_W | Sample to store (two's complement) |
| trig_in | input | 1 | External trigger, synchronous to clk |
| sample_out | output | DATA_W | Scaled, offset and clipped sample (signed) |

## Verification
The hardest situation to reach is the fold at the reset-default fold value, because the phase must cross the entire table before the fold happens. The bench loads a ramp, so each index maps to a unique sample value. It then leaves the fold value untouched and uses a coarse increment, which completes a lap in eight samples and lands a nonzero start phase exactly on a carry-over. The single-pass stop and the edge triggers are reached the same way. The bench parks the sequencer with hold, changes the control word, and counts edges from the release so that each index is checked on its exact cycle.

// File: rtl/wg_pkg.sv
package wg_pkg;

  typedef enum logic [2:0] {
    TRG_NEVER  = 3'd0,
    TRG_NOW    = 3'd1,
    TRG_RISE   = 3'd2,
    TRG_FALL   = 3'd3,
    TRG_LEVEL  = 3'd4,
    TRG_ALWAYS = 3'd5
  } trig_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;

  // control word, LSB first: source, single-pass, carry fold, zero, hold
  typedef struct packed {
    logic      hold;
    logic      zero;
    logic      carry_fold;
    logic      single;
    trig_src_e src;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wg_regs.sv
module wg_regs
  import wg_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int DATA_W  = 14,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [2:0]         addr,
  input  logic [PHASE_W-1:0] wdata,
  output ctrl_t              ctrl,
  output logic [DATA_W-1:0]  gain,
  output logic [DATA_W-1:0]  offs,
  output logic [PHASE_W-1:0] fold,
  output logic [PHASE_W-1:0] start_ph,
  output logic [PHASE_W-1:0] step
);

  localparam int OFF_LSB = 16;
  localparam logic [PHASE_W-1:0] FOLD_RST = PHASE_W'((64'd1 << (FRAC_W + ADDR_W)) - 64'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      gain     <= '0;
      offs     <= '0;
      fold     <= FOLD_RST;
      start_ph <= '0;
      step     <= '0;
    end else if (we) begin
      unique case (addr)
        3'd0: ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        3'd1: begin
          gain <= wdata[DATA_W-1:0];
          offs <= wdata[OFF_LSB+DATA_W-1:OFF_LSB];
        end
        3'd2: fold     <= wdata;
        3'd3: start_ph <= wdata;
        3'd4: step     <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wg_phase.sv
module wg_phase
  import wg_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic [PHASE_W-1:0] fold,
  input  logic [PHASE_W-1:0] start_ph,
  input  logic [PHASE_W-1:0] step,
  input  logic               trig_in,
  output logic [PHASE_W-1:0] ph,
  output seq_st_e            st
);

  logic             trig_d;
  logic             fire;
  logic [PHASE_W:0] sum;
  logic             over;
  logic [PHASE_W:0] carried;

  always_comb begin
    unique case (ctrl.src)
      TRG_NOW, TRG_ALWAYS: fire = 1'b1;
      TRG_RISE:            fire = trig_in & ~trig_d;
      TRG_FALL:            fire = ~trig_in & trig_d;
      TRG_LEVEL:           fire = trig_in;
      default:             fire = 1'b0;
    endcase
  end

  assign sum     = {1'b0, ph} + {1'b0, step};
  assign over    = sum > {1'b0, fold};
  assign carried = sum - {1'b0, fold} - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d <= 1'b0;
      ph     <= '0;
      st     <= ST_IDLE;
    end else begin
      trig_d <= trig_in;
      if (ctrl.hold) begin
        ph <= '0;
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (fire) begin
            ph <= start_ph;
            st <= ST_RUN;
          end
          ST_RUN: begin
            if (!over)                ph <= sum[PHASE_W-1:0];
            else if (ctrl.single)     st <= ST_DONE;
            else if (ctrl.carry_fold) ph <= carried[PHASE_W-1:0];
            else                      ph <= '0;
          end
          default: st <= ST_DONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/wg_table.sv
module wg_table #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/wg_scale.sv
module wg_scale #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] samp,
  input  logic [DATA_W-1:0] gain,
  input  logic [DATA_W-1:0] offs,
  input  logic              zero,
  output logic [DATA_W-1:0] y
);

  localparam int PRD_W = 2 * DATA_W + 1;
  localparam int ACC_W = PRD_W + 1;
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -Y_MAX - ACC_W'(1);

  logic signed [PRD_W-1:0] prod;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] clip;

  always_comb begin
    prod = $signed(samp) * $signed({1'b0, gain});
    acc  = ACC_W'(prod >>> (DATA_W - 1)) + ACC_W'($signed(offs));
    if (acc > Y_MAX)      clip = Y_MAX;
    else if (acc < Y_MIN) clip = Y_MIN;
    else                  clip = acc;
  end

  always_ff @(posedge clk) begin
    if (rst || zero) y <= '0;
    else             y <= clip[DATA_W-1:0];
  end

endmodule

// File: rtl/tbl_wavegen.sv
module tbl_wavegen
  import wg_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int DATA_W  = 14,
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [PHASE_W-1:0] cfg_wdata,
  input  logic               tbl_we,
  input  logic [ADDR_W-1:0]  tbl_addr,
  input  logic [DATA_W-1:0]  tbl_wdata,
  input  logic               trig_in,
  output logic [DATA_W-1:0]  sample_out
);

  ctrl_t              ctrl;
  logic [DATA_W-1:0]  gain;
  logic [DATA_W-1:0]  offs;
  logic [PHASE_W-1:0] fold;
  logic [PHASE_W-1:0] start_ph;
  logic [PHASE_W-1:0] step;
  logic [PHASE_W-1:0] ph;
  seq_st_e            st;
  logic [DATA_W-1:0]  tbl_q;
  logic [ADDR_W-1:0]  rd_idx;
  logic               unused_ph_bits;

  assign rd_idx         = ph[FRAC_W+ADDR_W-1:FRAC_W];
  assign unused_ph_bits = ^{ph[PHASE_W-1:FRAC_W+ADDR_W], ph[FRAC_W-1:0]};

  wg_regs #(
    .PHASE_W(PHASE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .gain(gain), .offs(offs), .fold(fold),
    .start_ph(start_ph), .step(step)
  );

  wg_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .ctrl(ctrl), .fold(fold), .start_ph(start_ph),
    .step(step), .trig_in(trig_in), .ph(ph), .st(st)
  );

  wg_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(rd_idx), .rdata(tbl_q)
  );

  wg_scale #(.DATA_W(DATA_W)) u_scale (
    .clk(clk), .rst(rst), .samp(tbl_q), .gain(gain), .offs(offs),
    .zero(ctrl.zero), .y(sample_out)
  );

endmodule

// File: rtl/wg_checker.sv
module wg_checker
  import wg_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int DATA_W  = 14
) (
  input logic               clk,
  input logic               rst,
  input ctrl_t              ctrl,
  input logic [PHASE_W-1:0] ph,
  input seq_st_e            st,
  input logic [PHASE_W-1:0] start_ph,
  input logic [PHASE_W-1:0] step,
  input logic [PHASE_W-1:0] fold,
  input logic [DATA_W-1:0]  sample_out
);

  logic [PHASE_W:0] nxt;
  logic             past_fold;
  assign nxt       = {1'b0, ph} + {1'b0, step};
  assign past_fold = nxt > {1'b0, fold};

  p_reset_out_r1: assert property (@(posedge clk) rst |=> sample_out == '0);

  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !ctrl.hold && !past_fold) |=> ph == $past(nxt[PHASE_W-1:0]));

  p_carry_fold_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !ctrl.hold && past_fold && !ctrl.single && ctrl.carry_fold)
    |=> ph == $past(nxt[PHASE_W-1:0] - fold - 1'b1));

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !ctrl.hold && past_fold && !ctrl.single && !ctrl.carry_fold)
    |=> ph == '0);

  p_single_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !ctrl.hold && past_fold && ctrl.single)
    |=> st == ST_DONE && $stable(ph));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE && !ctrl.hold) |=> st == ST_DONE && $stable(ph));

  p_start_load_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !ctrl.hold && ctrl.src == TRG_NOW)
    |=> st == ST_RUN && ph == $past(start_ph));

  p_zero_out_r11: assert property (@(posedge clk) disable iff (rst)
    ctrl.zero |=> sample_out == '0);

  p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
    ctrl.hold |=> st == ST_IDLE && ph == '0);

endmodule

bind tbl_wavegen wg_checker #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .ph(ph), .st(st), .start_ph(start_ph),
  .step(step), .fold(fold), .sample_out(sample_out)
);

// File: tb/tb_tbl_wavegen.sv
`timescale 1ns/1ps
module tb_tbl_wavegen;

  localparam int PW = 32;
  localparam int DW = 14;
  localparam int AW = 10;
  localparam int FW = 16;

  // scaling vectors: sample, gain, offset, expected output
  localparam int VEC[10][4] = '{
    '{ 1000,  8192,     0,  1000},
    '{ 1000,  4096,     0,   500},
    '{-1001,  4096,     0,  -501},
    '{ 6000, 16383,     0,  8191},
    '{-6000, 16383,     0, -8192},
    '{  100,  8192,  8000,  8100},
    '{  300,  8192,  8000,  8191},
    '{ -300,  8192, -8000, -8192},
    '{    0,     0, -1234, -1234},
    '{ 8191, 16383, -8192,  8189}
  };
  localparam int SEQ_DEF[10]   = '{64, 192, 320, 448, 576, 704, 832, 960, 64, 192};
  localparam int SEQ_CARRY[10] = '{0, 3, 6, 1, 4, 7, 2, 5, 0, 3};
  localparam int SEQ_RST[10]   = '{0, 3, 6, 0, 3, 6, 0, 3, 6, 0};
  localparam int SEQ_ONE[10]   = '{2, 3, 4, 5, 6, 7, 7, 7, 7, 7};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic          tbl_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [DW-1:0] tbl_wdata = '0;
  logic          trig_in = 1'b0;
  logic signed [DW-1:0] sample_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  tbl_wavegen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .trig_in(trig_in), .sample_out(sample_out)
  );

  function automatic int memv(int i);
    return i * 3 - 500;
  endfunction

  function automatic logic [PW-1:0] ctl(int src, bit single, bit carry, bit zero, bit hold);
    return PW'({hold, zero, carry, single, 3'(src)});
  endfunction

  function automatic logic [PW-1:0] scl(int gain, int off);
    return PW'(((off & 16'h3FFF) << 16) | (gain & 16'h3FFF));
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cfg(int a, logic [PW-1:0] d);
    @(negedge clk);
    cfg_addr = 3'(a); cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tbl(int a, int d);
    @(negedge clk);
    tbl_addr = AW'(a); tbl_wdata = DW'(d); tbl_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // called right after the releasing control write
  task automatic run_seq(string req, int seq[10]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      if (k > 0) @(negedge clk);
      check(req, int'(sample_out), memv(seq[k]));
    end
  endtask

  task automatic wait_check(string req, int n, int exp);
    repeat (n) @(posedge clk);
    @(negedge clk);
    check(req, int'(sample_out), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 output during reset", int'(sample_out), 0);
    rst = 1'b0;
    wait_check("R1 gain clear after reset", 2, 0);

    // ramp table, one write per clock
    for (int i = 0; i < 2 ** AW; i++) begin
      @(negedge clk);
      tbl_addr = AW'(i); tbl_wdata = DW'(memv(i)); tbl_we = 1'b1;
    end
    @(negedge clk);
    tbl_we = 1'b0;

    cfg(1, scl(8192, 0));
    cfg(0, ctl(0, 0, 0, 0, 1));
    wait_check("R12 hold shows entry 0", 3, memv(0));

    // R1/R6: default fold value untouched
    cfg(4, PW'(128 << FW));
    cfg(3, PW'(64 << FW));
    cfg(0, ctl(1, 0, 1, 0, 0));
    run_seq("R1 R6 default fold carry", SEQ_DEF);

    cfg(0, ctl(0, 0, 0, 0, 1));
    wait_check("R12 hold returns to entry 0", 3, memv(0));

    cfg(2, PW'((8 << FW) - 1));
    cfg(4, PW'(3 << FW));
    cfg(3, 0);
    cfg(0, ctl(1, 0, 1, 0, 0));
    run_seq("R5 R6 carry fold sequence", SEQ_CARRY);

    cfg(0, ctl(0, 0, 0, 0, 1));
    cfg(0, ctl(1, 0, 0, 0, 0));
    run_seq("R7 restart at zero", SEQ_RST);

    cfg(0, ctl(0, 0, 0, 0, 1));
    cfg(4, PW'(1 << FW));
    cfg(3, PW'(2 << FW));
    cfg(0, ctl(1, 1, 0, 0, 0));
    run_seq("R4 R8 single pass", SEQ_ONE);
    wait_check("R8 last sample held", 20, memv(7));

    // trigger sources, increment 0 so the start index stays visible
    cfg(0, ctl(0, 0, 0, 0, 1));
    cfg(4, 0);
    cfg(3, PW'(5 << FW));

    cfg(0, ctl(0, 0, 0, 0, 0));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      trig_in = ~trig_in;
    end
    trig_in = 1'b0;
    wait_check("R9 source 0 ignores trigger", 4, memv(0));

    cfg(0, ctl(0, 0, 0, 0, 1));
    cfg(0, ctl(2, 0, 0, 0, 0));
    wait_check("R10 rising waits for edge", 5, memv(0));
    @(negedge clk); trig_in = 1'b1;
    wait_check("R9 R10 rising edge loads start", 3, memv(5));

    cfg(0, ctl(0, 0, 0, 0, 1));
    cfg(0, ctl(3, 0, 0, 0, 0));
    wait_check("R10 falling ignores steady high", 5, memv(0));
    @(negedge clk); trig_in = 1'b0;
    wait_check("R9 R10 falling edge loads start", 3, memv(5));

    cfg(0, ctl(0, 0, 0, 0, 1));
    cfg(0, ctl(4, 0, 0, 0, 0));
    wait_check("R9 level low starts nothing", 5, memv(0));
    @(negedge clk); trig_in = 1'b1;
    wait_check("R9 level high loads start", 3, memv(5));
    @(negedge clk); trig_in = 1'b0;

    cfg(0, ctl(0, 0, 0, 0, 1));
    cfg(0, ctl(5, 0, 0, 0, 0));
    wait_check("R9 always source loads start", 3, memv(5));

    // zero forcing and one-edge config latency
    cfg(0, ctl(0, 0, 0, 1, 1));
    @(posedge clk); @(negedge clk);
    check("R11 R4 zero forced next edge", int'(sample_out), 0);
    cfg(0, ctl(0, 0, 0, 0, 1));
    @(posedge clk); @(negedge clk);
    check("R11 R4 zero released next edge", int'(sample_out), memv(0));

    // scaling and saturation vectors, phase held at 0
    for (int v = 0; v < 10; v++) begin
      tbl(0, VEC[v][0]);
      cfg(1, scl(VEC[v][1], VEC[v][2]));
      @(posedge clk); @(negedge clk);
      check((VEC[v][3] == 8191 || VEC[v][3] == -8192) ? "R3 saturation" : "R2 scale offset",
            int'(sample_out), VEC[v][3]);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1-chain got timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule